// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Distributed Refresh

This controller connects a simple request port to a DRAM array whose address pins are half as wide as the word address. Each accepted request carries a 20-bit word address, a read/write flag and a 4-bit write value. The controller first places the row half of the address on the shared pin bus and then lowers the row strobe. Next it places the column half on the same bus and lowers the column strobe. A read returns its 4-bit value through a one-cycle valid pulse. The array holds 1M words of 4 bits.

Stored charge in the array decays, so the controller refreshes it one row at a time. A timer fires at a fixed interval, measured in clock cycles. Each time it fires, the controller runs one refresh cycle that uses the row strobe only, with the row taken from an internal refresh counter. A 2:1 selector chooses whether that counter or the requester's row bits drive the row address. Refresh cycles never overlap accesses. A refresh that falls due during an access waits for that access to finish and then runs before the next request is accepted.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The low address half `req_addr[9:0]` appears on `dram_addr` when the row strobe falls. The high half `req_addr[19:10]` appears on `dram_addr` when the column strobe falls.
- R2: Both strobes are active low. Each strobe falls one clock after its address half is first driven, and `dram_addr` holds the same value across that falling edge.
- R3: A write stores the 4-bit value at the full 20-bit address. A later read of that address returns the value on `rd_data`, together with a `rd_valid` pulse that lasts exactly one cycle.
- R4: The row strobe stays low for exactly 3 cycles in reads, writes and refreshes alike. Back-to-back accesses start a new row strobe every 6 cycles.
- R5: A refresh cycle lowers the row strobe with no column strobe. Its row comes from the refresh counter, which starts at 0 after reset, advances by one after each refresh and wraps from 1023 to 0.
- R6: When no requests arrive, consecutive refresh cycles start exactly `REFI_CYCLES` cycles apart.
- R7: A refresh that falls due during an access waits and then takes priority over a pending request. Under continuous requests, the gap between refreshes never exceeds `REFI_CYCLES`+6 cycles.
- R8: `req_ready` is low whenever an access or refresh is in progress, which includes every cycle with the row strobe low.
- R9: During a write, `dram_we_n` is low and `dram_dq_oe` is high through the column phase. During a read, `dram_we_n` stays high.
- R10: After reset, both strobes and `dram_we_n` are high, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write value |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rd_valid | output | 1 | Read value valid (one cycle) |
| rd_data | output | 4 | Read value |
| dram_addr | output | 10 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 4 | Data to the array |
| dram_dq_oe | output | 1 | Data drive enable toward the array |
| dram_dq_in | input | 4 | Data from the array |

## Verification
The hardest case to reach is a refresh timer that expires in the middle of an access while another request is already waiting. The bench creates it by holding `req_valid` high for many refresh intervals, so expiries land at every phase of the access cycle. It then measures the largest gap between row-strobe-only cycles and confirms that reads kept returning correct data. Reaching the counter wrap requires more than 1024 refreshes, so the bench uses a short interval and idles until it sees row 0 follow row 1023.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AROW,
    ST_ARAS,
    ST_ACOL,
    ST_ACAS,
    ST_APRE,
    ST_RROW,
    ST_RRAS,
    ST_RHLD1,
    ST_RHLD2,
    ST_RPRE
  } ctl_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= RELOAD;
      pend <= 1'b0;
    end else begin
      if (cnt == '0) begin
        cnt  <= RELOAD;
        pend <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        if (take) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_refresh_row.sv
module dram_refresh_row #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)       row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int HALF_W = 10
) (
  input  logic              sel_ref,
  input  logic              sel_col,
  input  logic [HALF_W-1:0] req_row,
  input  logic [HALF_W-1:0] req_col,
  input  logic [HALF_W-1:0] ref_row,
  output logic [HALF_W-1:0] pin_addr
);
  logic [HALF_W-1:0] row_pick;

  always_comb begin
    row_pick = sel_ref ? ref_row : req_row;
    pin_addr = sel_col ? req_col : row_pick;
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_mux_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic pend,
  input  logic wr,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dq_oe,
  output logic ready,
  output logic accept,
  output logic take_ref,
  output logic step_row,
  output logic capture,
  output logic drive_addr,
  output logic sel_ref,
  output logic sel_col
);
  ctl_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (pend) nxt = ST_RROW;
                else if (req_valid) nxt = ST_AROW;
      ST_AROW:  nxt = ST_ARAS;
      ST_ARAS:  nxt = ST_ACOL;
      ST_ACOL:  nxt = ST_ACAS;
      ST_ACAS:  nxt = ST_APRE;
      ST_APRE:  nxt = ST_IDLE;
      ST_RROW:  nxt = ST_RRAS;
      ST_RRAS:  nxt = ST_RHLD1;
      ST_RHLD1: nxt = ST_RHLD2;
      ST_RHLD2: nxt = ST_RPRE;
      ST_RPRE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign ready      = (state == ST_IDLE) && !pend;
  assign accept     = ready && req_valid;
  assign take_ref   = (state == ST_IDLE) && pend;
  assign step_row   = (state == ST_RPRE);
  assign capture    = (state == ST_ACAS) && !wr;
  assign drive_addr = (nxt == ST_AROW) || (nxt == ST_ACOL) || (nxt == ST_RROW);
  assign sel_ref    = (nxt == ST_RROW);
  assign sel_col    = (nxt == ST_ACOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      ras_n <= !(nxt inside {ST_ARAS, ST_ACOL, ST_ACAS, ST_RRAS, ST_RHLD1, ST_RHLD2});
      cas_n <= !(nxt == ST_ACAS);
      we_n  <= !(wr && (nxt inside {ST_ACOL, ST_ACAS}));
      dq_oe <= wr && (nxt inside {ST_ACOL, ST_ACAS});
    end
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 4,
  parameter int REFI_CYCLES = 390
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int HALF_W = ADDR_W / 2;

  logic              pend, take_ref, step_row, accept, capture;
  logic              drive_addr, sel_ref, sel_col, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HALF_W-1:0] ref_row, mux_addr, row_src;

  dram_refresh_timer #(.INTERVAL(REFI_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .take(take_ref), .pend(pend)
  );

  dram_refresh_row #(.ROW_W(HALF_W)) u_rowcnt (
    .clk(clk), .rst(rst), .step(step_row), .row(ref_row)
  );

  dram_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pend(pend), .wr(wr_q),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .dq_oe(dram_dq_oe),
    .ready(req_ready), .accept(accept), .take_ref(take_ref), .step_row(step_row),
    .capture(capture), .drive_addr(drive_addr), .sel_ref(sel_ref), .sel_col(sel_col)
  );

  assign row_src = accept ? req_addr[HALF_W-1:0] : addr_q[HALF_W-1:0];

  dram_addr_mux #(.HALF_W(HALF_W)) u_mux (
    .sel_ref(sel_ref), .sel_col(sel_col), .req_row(row_src),
    .req_col(addr_q[ADDR_W-1:HALF_W]), .ref_row(ref_row), .pin_addr(mux_addr)
  );

  assign dram_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (drive_addr) dram_addr <= mux_addr;
      rd_valid <= capture;
      if (capture) rd_data <= dram_dq_in;
    end
  end
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int HALF_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              ready,
  input logic              rd_valid,
  input logic [HALF_W-1:0] pin_addr,
  input logic [HALF_W-1:0] ref_row
);
  AST_RAS_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(pin_addr)); // R2
  AST_CAS_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $stable(pin_addr)); // R2
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !ready); // R8
  AST_RD_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3
  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe); // R9
  AST_RAS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> !ras_n); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (ref_row != $past(ref_row)) |-> (ref_row == HALF_W'($past(ref_row) + 1'b1))); // R5
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .dq_oe(dram_dq_oe), .ready(req_ready), .rd_valid(rd_valid), .pin_addr(dram_addr),
  .ref_row(ref_row)
);

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
  localparam int P    = 10;
  localparam int REFI = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0]  dram_dq_out, dram_dq_in;

  int errors = 0, checks = 0;

  always #(P/2) clk = ~clk;

  dram_mux_ctrl #(.REFI_CYCLES(REFI)) u_dram_mux_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural array model and strobe monitor
  logic [3:0] mem [int];
  logic [3:0] rd_drive = '0;
  logic [9:0] m_row, m_col, acc_row, acc_col;
  logic [9:0] exp_ref = '0;
  bit   m_cas_seen, m_armed, saw_wrap;
  time  m_fall, last_ref_fall, last_gap, max_gap, prev_acc_fall, acc_gap;
  int   ref_cnt = 0;
  assign dram_dq_in = rd_drive;

  always @(negedge dram_ras_n) if (!rst) begin
    m_fall = $time; m_row = dram_addr; m_cas_seen = 0; m_armed = 1;
  end

  always @(negedge dram_cas_n) if (!rst) begin
    m_col = dram_addr; m_cas_seen = 1; acc_row = m_row; acc_col = m_col;
    if (!dram_we_n) begin
      chk(dram_dq_oe, "R9 write drive", dram_dq_oe, 1);
      mem[int'({m_col, m_row})] = dram_dq_out;
    end else
      rd_drive = mem.exists(int'({m_col, m_row})) ? mem[int'({m_col, m_row})] : 4'h0;
  end

  always @(posedge dram_ras_n) if (!rst && m_armed) begin
    m_armed = 0;
    chk(($time - m_fall) == 3*P, "R4 strobe width", ($time - m_fall)/P, 3);
    if (!m_cas_seen) begin
      chk(m_row == exp_ref, "R5 refresh row", m_row, exp_ref);
      if (m_row == 10'd0 && ref_cnt > 0) saw_wrap = 1;
      if (ref_cnt > 0) begin
        last_gap = m_fall - last_ref_fall;
        if (last_gap > max_gap) max_gap = last_gap;
      end
      last_ref_fall = m_fall;
      exp_ref = exp_ref + 1'b1;
      ref_cnt++;
    end else begin
      acc_gap = m_fall - prev_acc_fall;
      prev_acc_fall = m_fall;
    end
  end

  // Stimulus table: {write, addr, data}
  localparam logic [24:0] VEC [9] = '{
    {1'b1, 20'h00000, 4'h5}, {1'b1, 20'hFFFFF, 4'hA}, {1'b1, 20'h003FF, 4'h3},
    {1'b1, 20'hFFC00, 4'hC}, {1'b0, 20'h00000, 4'h0}, {1'b0, 20'hFFFFF, 4'h0},
    {1'b0, 20'h003FF, 4'h0}, {1'b1, 20'h00000, 4'h9}, {1'b0, 20'h00000, 4'h0}
  };
  logic [3:0] exp_mem [int];

  task automatic wait_ready();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic do_acc(input bit w, input logic [19:0] a, input logic [3:0] d,
                        output logic [3:0] q, output bit got);
    got = 0; q = '0;
    wait_ready();
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 busy after accept", req_ready, 0);
    for (int i = 0; i < 40; i++) begin
      if (!w && rd_valid) begin got = 1; q = rd_data; end
      if (req_ready) break;
      @(negedge clk);
    end
  endtask

  bit done = 0;

  initial begin
    logic [3:0] q;
    bit got;
    int base, rd_bad, rd_seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(req_ready, "R10 ready", req_ready, 1);
    chk(!rd_valid, "R10 rd_valid", rd_valid, 0);

    // Table walk: R1, R3
    foreach (VEC[k]) begin
      do_acc(VEC[k][24], VEC[k][23:4], VEC[k][3:0], q, got);
      chk(acc_row == VEC[k][13:4], "R1 row half", acc_row, VEC[k][13:4]);
      chk(acc_col == VEC[k][23:14], "R1 column half", acc_col, VEC[k][23:14]);
      if (VEC[k][24]) exp_mem[int'(VEC[k][23:4])] = VEC[k][3:0];
      else begin
        chk(got, "R3 read returned", got, 1);
        chk(q == exp_mem[int'(VEC[k][23:4])], "R3 read data", q, exp_mem[int'(VEC[k][23:4])]);
      end
    end

    // R6 idle spacing
    base = ref_cnt;
    for (int i = 0; i < 4*REFI && ref_cnt < base + 2; i++) @(negedge clk);
    chk(last_gap == REFI*P, "R6 idle refresh gap", last_gap/P, REFI);

    // R4 back-to-back reads right after a refresh
    base = ref_cnt;
    for (int i = 0; i < 2*REFI && ref_cnt == base; i++) @(negedge clk);
    req_write = 0; req_addr = 20'hFFFFF; req_valid = 1;
    for (int i = 0; i < 17; i++) @(negedge clk);
    req_valid = 0;
    chk(acc_gap == 6*P, "R4 access period", acc_gap/P, 6);
    wait_ready();

    // R7 continuous requests across many refresh expiries
    max_gap = 0; base = ref_cnt; rd_bad = 0; rd_seen = 0;
    req_write = 0; req_addr = 20'hFFC00; req_valid = 1;
    for (int i = 0; i < 25*REFI; i++) begin
      @(negedge clk);
      if (rd_valid) begin rd_seen++; if (rd_data != 4'hC) rd_bad++; end
    end
    req_valid = 0;
    chk(max_gap <= (REFI+6)*P, "R7 refresh gap under load", max_gap/P, REFI+6);
    chk(ref_cnt - base >= 24, "R7 refresh count under load", ref_cnt - base, 24);
    chk(rd_bad == 0 && rd_seen > 50, "R3 reads under load", rd_bad, 0);
    wait_ready();

    // R5 wrap from 1023 to 0
    for (int i = 0; i < 40000 && ref_cnt < 1026; i++) @(negedge clk);
    chk(saw_wrap, "R5 counter wrap", saw_wrap, 1);

    // R9 read keeps we_n high
    fork
      do_acc(1'b0, 20'h00000, 4'h0, q, got);
      begin
        for (int i = 0; i < 12; i++) begin
          @(negedge clk);
          if (!dram_cas_n) chk(dram_we_n, "R9 read we_n", dram_we_n, 1);
        end
      end
    join
    chk(q == 4'h9, "R3 final read", q, 9);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(P*190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule